// File: doc/BRIEF.md
# IOMMU Configuration Register Block

This block holds the configuration registers of an I/O address translation unit. It keeps a control register and a translation-table base register, and it exposes a third flush register that software can write but that stores nothing. The three registers are reached over a simple single-cycle request bus. Each request is either a 64-bit access or a 32-bit access.

Every 64-bit register can be read or written as a whole, or as two 32-bit halves. The register's own offset selects the more significant half, and the offset plus four selects the less significant half, which matches big-endian ordering. A 32-bit write changes only the addressed half. Read data returns one cycle after the request. The stored control and base values drive the translation unit directly. After reset, every register is zero, which leaves translation disabled (pass-through).

Top module: `iommu_cfg_regs`

## Requirements
- R1: A synchronous active-high reset clears the control and base registers and every configuration output to zero. It also clears the response outputs `rsp_valid` and `rsp_rdata`.
- R2: A 64-bit write (`req_wide`=1) at offset 0x00 (control) or 0x08 (base) replaces all 64 bits with `req_wdata`. A 64-bit read at that offset returns all 64 bits.
- R3: A 32-bit write (`req_wide`=0) at a register's own offset loads `req_wdata[31:0]` into bits [63:32] and leaves bits [31:0] unchanged.
- R4: A 32-bit read at a register's own offset returns bits [63:32] of that register in `rsp_rdata[31:0]`, with `rsp_rdata[63:32]` equal to zero.
- R5: An access of either size at a register's offset plus 4 works on bits [31:0] only. A write loads `req_wdata[31:0]` into bits [31:0] and leaves bits [63:32] unchanged. A read returns bits [31:0] in `rsp_rdata[31:0]`, with the upper half zero.
- R6: Writes to the flush register (offset 0x10, or 0x14 for its lower half) are accepted and change nothing. Reads of the flush register return zero.
- R7: An access to any other offset reads as zero, and a write to it changes nothing. This covers offsets 0x18 and above, and any offset whose bits [1:0] are not zero.
- R8: `rsp_valid` is high for exactly one cycle, in the cycle after each read request, and is low at all other times. `rsp_rdata` is zero whenever `rsp_valid` is low.
- R9: The configuration outputs take their values from the control register and change in the cycle after the write that alters it:
  - the enable output comes from control bit 0;
  - the 64K-granule select comes from control bit 2;
  - the table-size field comes from control bits [18:16].
- R10: The base output equals the whole base register and changes in the cycle after the write that alters it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is present in this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| req_addr | input | ADDR_W | Byte offset inside the block |
| req_wdata | input | 64 | Write data; 32-bit accesses use bits [31:0] |
| rsp_valid | output | 1 | Read data is valid in this cycle |
| rsp_rdata | output | 64 | Read data; 32-bit reads return data in bits [31:0] |
| xlat_enable | output | 1 | Translation enable (control bit 0) |
| xlat_gran_64k | output | 1 | Table granularity select (control bit 2) |
| xlat_tbl_size | output | 3 | Table size code (control bits [18:16]) |
| xlat_tbl_base | output | 64 | Translation table base register |

## Verification
The assertions check the following on every cycle:
- the one-cycle read response and its idle zero data;
- the zero upper half on every 32-bit or plus-four read;
- the zero data returned for flush and unmapped reads;
- that a half not selected by the write strobes never moves;
- that flush writes leave both stored registers unchanged;
- the reset clearing.

Only the bench's scenarios can show the actual merge values: which bits of the write data land in which half, and which half a given size and offset returns. They are also the only way to see the control fields reaching their outputs, a misaligned offset being treated as unmapped, and a reset in mid-run clearing state that was loaded earlier.

// File: rtl/iommu_cfg_pkg.sv
package iommu_cfg_pkg;

  // Width of each stored register.
  localparam int unsigned REG_W  = 64;
  localparam int unsigned HALF_W = REG_W / 2;

  // Number of registers that actually hold state (control and base).
  localparam int unsigned NUM_STORED = 2;

  // Register index = byte offset / 8.
  localparam int unsigned IDX_CTRL  = 0;
  localparam int unsigned IDX_BASE  = 1;
  localparam int unsigned IDX_FLUSH = 2;

  // Positions of the fields inside the control register.
  localparam int unsigned CTL_EN_BIT   = 0;
  localparam int unsigned CTL_GRAN_BIT = 2;
  localparam int unsigned CTL_SIZE_LSB = 16;
  localparam int unsigned CTL_SIZE_W   = 3;

  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_CTRL  = 2'd1,
    SEL_BASE  = 2'd2,
    SEL_FLUSH = 2'd3
  } reg_sel_e;

  typedef struct packed {
    reg_sel_e sel;      // target register
    logic     lo_half;  // offset + 4: less significant half
    logic     wide;     // 64-bit access
  } acc_dec_t;

endpackage

// File: rtl/iommu_cfg_decode.sv
module iommu_cfg_decode
  import iommu_cfg_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wide,
  output acc_dec_t          dec
);

  localparam int unsigned IDX_W = ADDR_W - 3;

  logic [IDX_W-1:0] idx;
  logic             aligned;

  assign idx     = addr[ADDR_W-1:3];
  assign aligned = (addr[1:0] == 2'b00);

  always_comb begin
    dec.wide    = wide;
    dec.lo_half = addr[2];
    dec.sel     = SEL_NONE;
    if (aligned) begin
      if (idx == IDX_W'(IDX_CTRL)) begin
        dec.sel = SEL_CTRL;
      end else if (idx == IDX_W'(IDX_BASE)) begin
        dec.sel = SEL_BASE;
      end else if (idx == IDX_W'(IDX_FLUSH)) begin
        dec.sel = SEL_FLUSH;
      end
    end
  end

endmodule

// File: rtl/iommu_cfg_halfreg.sv
module iommu_cfg_halfreg #(
  parameter int unsigned W = 64
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_hi,
  input  logic           wr_lo,
  input  logic [W/2-1:0] din_hi,
  input  logic [W/2-1:0] din_lo,
  output logic [W-1:0]   q
);

  localparam int unsigned H = W / 2;

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else begin
      if (wr_hi) q[W-1:H] <= din_hi;
      if (wr_lo) q[H-1:0] <= din_lo;
    end
  end

  // R3: a write that does not target the upper half leaves it unchanged.
  a_r3_upper_kept: assert property (@(posedge clk) disable iff (rst)
    !wr_hi |=> $stable(q[W-1:H]));

  // R5: a write that does not target the lower half leaves it unchanged.
  a_r5_lower_kept: assert property (@(posedge clk) disable iff (rst)
    !wr_lo |=> $stable(q[H-1:0]));

endmodule

// File: rtl/iommu_cfg_rdmux.sv
module iommu_cfg_rdmux
  import iommu_cfg_pkg::*;
(
  input  acc_dec_t         dec,
  input  logic [REG_W-1:0] ctrl,
  input  logic [REG_W-1:0] base,
  output logic [REG_W-1:0] data
);

  logic [REG_W-1:0] chosen;
  logic             stored_hit;

  always_comb begin
    stored_hit = 1'b1;
    chosen     = '0;
    unique case (dec.sel)
      SEL_CTRL: chosen = ctrl;
      SEL_BASE: chosen = base;
      default:  stored_hit = 1'b0;
    endcase
  end

  always_comb begin
    data = '0;
    if (stored_hit) begin
      if (dec.lo_half) begin
        data[HALF_W-1:0] = chosen[HALF_W-1:0];
      end else if (dec.wide) begin
        data = chosen;
      end else begin
        data[HALF_W-1:0] = chosen[REG_W-1:HALF_W];
      end
    end
  end

endmodule

// File: rtl/iommu_cfg_regs.sv
module iommu_cfg_regs
  import iommu_cfg_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_wide,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [63:0]       req_wdata,
  output logic              rsp_valid,
  output logic [63:0]       rsp_rdata,
  output logic              xlat_enable,
  output logic              xlat_gran_64k,
  output logic [2:0]        xlat_tbl_size,
  output logic [63:0]       xlat_tbl_base
);

  acc_dec_t         dec;
  logic [REG_W-1:0] stored [NUM_STORED];
  logic [REG_W-1:0] ctrl_q;
  logic [REG_W-1:0] base_q;
  logic [REG_W-1:0] rd_next;
  logic             wr_any;
  logic             rd_req;

  assign wr_any = req_valid && req_write;
  assign rd_req = req_valid && !req_write;

  iommu_cfg_decode #(.ADDR_W(ADDR_W)) i_decode (
    .addr (req_addr),
    .wide (req_wide),
    .dec  (dec)
  );

  for (genvar gi = 0; gi < NUM_STORED; gi++) begin : g_reg
    localparam reg_sel_e MY_SEL = (gi == IDX_CTRL) ? SEL_CTRL : SEL_BASE;
    logic              hit;
    logic              wr_hi;
    logic              wr_lo;
    logic [HALF_W-1:0] din_hi;

    assign hit    = wr_any && (dec.sel == MY_SEL);
    assign wr_hi  = hit && !dec.lo_half;
    assign wr_lo  = hit && (dec.lo_half || dec.wide);
    assign din_hi = dec.wide ? req_wdata[REG_W-1:HALF_W] : req_wdata[HALF_W-1:0];

    iommu_cfg_halfreg #(.W(REG_W)) i_reg (
      .clk    (clk),
      .rst    (rst),
      .wr_hi  (wr_hi),
      .wr_lo  (wr_lo),
      .din_hi (din_hi),
      .din_lo (req_wdata[HALF_W-1:0]),
      .q      (stored[gi])
    );
  end

  assign ctrl_q = stored[IDX_CTRL];
  assign base_q = stored[IDX_BASE];

  iommu_cfg_rdmux i_rdmux (
    .dec  (dec),
    .ctrl (ctrl_q),
    .base (base_q),
    .data (rd_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_req;
      rsp_rdata <= rd_req ? rd_next : '0;
    end
  end

  assign xlat_enable   = ctrl_q[CTL_EN_BIT];
  assign xlat_gran_64k = ctrl_q[CTL_GRAN_BIT];
  assign xlat_tbl_size = ctrl_q[CTL_SIZE_LSB +: CTL_SIZE_W];
  assign xlat_tbl_base = base_q;

  // R1: reset clears stored state and the response outputs.
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (ctrl_q == '0 && base_q == '0 && !rsp_valid && rsp_rdata == '0));

  // R8: every read request produces a response in the next cycle.
  a_r8_read_answered: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> rsp_valid);

  // R8: no response appears without a read request in the cycle before.
  a_r8_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !rd_req |=> (!rsp_valid && rsp_rdata == '0));

  // R4: a 32-bit read, or a read at offset + 4, returns zero in the upper half.
  a_r4_narrow_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_req && (!req_wide || req_addr[2])) |=> (rsp_rdata[63:32] == '0));

  // R6 and R7: flush and unmapped reads return zero.
  a_r6_r7_read_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_req && (dec.sel == SEL_FLUSH || dec.sel == SEL_NONE)) |=> (rsp_rdata == '0));

  // R6 and R7: flush and unmapped writes change no stored register.
  a_r6_r7_write_ignored: assert property (@(posedge clk) disable iff (rst)
    (wr_any && (dec.sel == SEL_FLUSH || dec.sel == SEL_NONE)) |=>
      ($stable(ctrl_q) && $stable(base_q)));

endmodule

// File: tb/test_iommu_cfg_regs.sv
module test_iommu_cfg_regs;

  localparam int ADDR_W = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid = 1'b0;
  logic              req_write = 1'b0;
  logic              req_wide  = 1'b0;
  logic [ADDR_W-1:0] req_addr  = '0;
  logic [63:0]       req_wdata = '0;
  logic              rsp_valid;
  logic [63:0]       rsp_rdata;
  logic              xlat_enable;
  logic              xlat_gran_64k;
  logic [2:0]        xlat_tbl_size;
  logic [63:0]       xlat_tbl_base;

  always #2.5 clk = ~clk;

  iommu_cfg_regs #(.ADDR_W(ADDR_W)) i_iommu_cfg_regs (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_write     (req_write),
    .req_wide      (req_wide),
    .req_addr      (req_addr),
    .req_wdata     (req_wdata),
    .rsp_valid     (rsp_valid),
    .rsp_rdata     (rsp_rdata),
    .xlat_enable   (xlat_enable),
    .xlat_gran_64k (xlat_gran_64k),
    .xlat_tbl_size (xlat_tbl_size),
    .xlat_tbl_base (xlat_tbl_base)
  );

  int    n_checks = 0;
  int    n_fail   = 0;
  int    cycles   = 0;
  string cur_req  = "R1";
  string m_tag    = "R1";

  // Behavioural reference state.
  logic [63:0] m_regs [2];
  logic        m_rv;
  logic [63:0] m_rd;

  function automatic logic [63:0] ref_read(input logic [ADDR_W-1:0] a, input logic w);
    int          idx;
    logic [63:0] r;
    if (a % 4 != 0) return 64'd0;
    idx = int'(a) / 8;
    if (idx > 1) return 64'd0;
    r = m_regs[idx];
    if (a % 8 == 4) return {32'd0, r[31:0]};
    if (w) return r;
    return {32'd0, r[63:32]};
  endfunction

  always @(posedge clk) begin
    m_tag <= cur_req;
    if (rst) begin
      m_regs[0] <= 64'd0;
      m_regs[1] <= 64'd0;
      m_rv      <= 1'b0;
      m_rd      <= 64'd0;
    end else begin
      m_rv <= req_valid && !req_write;
      m_rd <= (req_valid && !req_write) ? ref_read(req_addr, req_wide) : 64'd0;
      if (req_valid && req_write && (req_addr % 4 == 0) && (int'(req_addr) / 8 < 2)) begin
        if (req_addr % 8 == 4)
          m_regs[int'(req_addr) / 8][31:0] <= req_wdata[31:0];
        else if (req_wide)
          m_regs[int'(req_addr) / 8] <= req_wdata;
        else
          m_regs[int'(req_addr) / 8][63:32] <= req_wdata[31:0];
      end
    end
  end

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Compare against the model on every falling edge once it is defined.
  logic model_live = 1'b0;
  always @(negedge clk) begin
    cycles++;
    if (model_live) begin
      check(m_tag, "rsp_valid (R8)", {63'd0, rsp_valid}, {63'd0, m_rv});
      check(m_tag, "rsp_rdata",      rsp_rdata, m_rd);
      check(m_tag, "enable (R9)",    {63'd0, xlat_enable},   {63'd0, m_regs[0][0]});
      check(m_tag, "granule (R9)",   {63'd0, xlat_gran_64k}, {63'd0, m_regs[0][2]});
      check(m_tag, "size (R9)",      {61'd0, xlat_tbl_size}, {61'd0, m_regs[0][18:16]});
      check(m_tag, "base (R10)",     xlat_tbl_base, m_regs[1]);
    end
    if (cycles > 20000) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  task automatic op(input string tag, input logic wr, input logic wide,
                    input logic [ADDR_W-1:0] a, input logic [63:0] d);
    @(negedge clk);
    cur_req   = tag;
    req_valid = 1'b1;
    req_write = wr;
    req_wide  = wide;
    req_addr  = a;
    req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    req_write = 1'b0;
    req_wdata = '0;
  endtask

  task automatic do_reset(input string tag);
    @(negedge clk);
    cur_req = tag;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    model_live = 1'b1;
    rst = 1'b0;

    // R1: reset state
    op("R1", 0, 1, 8'h00, 0);
    op("R1", 0, 1, 8'h08, 0);

    // R2: full-width access on both registers
    op("R2", 1, 1, 8'h00, 64'h0123_4567_89AB_CDEF);
    op("R2", 0, 1, 8'h00, 0);
    op("R10", 1, 1, 8'h08, 64'hFEDC_BA98_7654_3210);
    op("R2", 0, 1, 8'h08, 0);

    // R3/R4: narrow access at the register's own offset
    op("R3", 1, 0, 8'h00, 64'hFFFF_FFFF_1111_2222);
    op("R3", 0, 1, 8'h00, 0);
    op("R4", 0, 0, 8'h00, 0);
    op("R3", 1, 0, 8'h08, 64'h0000_0000_AAAA_5555);
    op("R4", 0, 0, 8'h08, 0);

    // R5: offset + 4, both sizes
    op("R5", 1, 0, 8'h04, 64'h0000_0000_0007_0004);
    op("R5", 1, 1, 8'h0C, 64'h9999_9999_DEAD_BEEF);
    op("R5", 0, 0, 8'h04, 0);
    op("R5", 0, 1, 8'h0C, 0);
    op("R5", 0, 1, 8'h08, 0);

    // R9: control fields reach the outputs
    op("R9", 1, 1, 8'h00, 64'h0000_0000_0005_0005);
    op("R9", 1, 1, 8'h00, 64'hFFFF_FFFF_FFFA_FFFA);
    op("R9", 1, 0, 8'h04, 64'h0000_0000_0003_0001);

    // R6: flush register writes ignored, reads zero
    op("R6", 1, 1, 8'h10, 64'hFFFF_FFFF_FFFF_FFFF);
    op("R6", 1, 0, 8'h10, 64'hFFFF_FFFF_FFFF_FFFF);
    op("R6", 1, 0, 8'h14, 64'hFFFF_FFFF_FFFF_FFFF);
    op("R6", 0, 1, 8'h10, 0);
    op("R6", 0, 0, 8'h14, 0);

    // R7: unmapped and misaligned offsets
    op("R7", 1, 1, 8'h18, 64'hFFFF_FFFF_FFFF_FFFF);
    op("R7", 1, 1, 8'hF8, 64'hFFFF_FFFF_FFFF_FFFF);
    op("R7", 1, 0, 8'h01, 64'hFFFF_FFFF_FFFF_FFFF);
    op("R7", 1, 1, 8'h0A, 64'hFFFF_FFFF_FFFF_FFFF);
    op("R7", 0, 1, 8'h18, 0);
    op("R7", 0, 1, 8'h02, 0);
    op("R7", 0, 1, 8'h00, 0);
    op("R7", 0, 1, 8'h08, 0);

    // R8: back-to-back reads keep rsp_valid high each cycle
    @(negedge clk);
    cur_req = "R8";
    req_valid = 1'b1; req_write = 1'b0; req_wide = 1'b1; req_addr = 8'h00;
    @(negedge clk);
    req_addr = 8'h08;
    @(negedge clk);
    req_wide = 1'b0; req_addr = 8'h0C;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (2) @(negedge clk);

    // R1: mid-run reset clears loaded state
    do_reset("R1");
    op("R1", 0, 1, 8'h00, 0);
    op("R1", 0, 1, 8'h08, 0);

    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule